// File: doc/BRIEF.md
# Push Buffer Command Fetcher

This block walks one channel's command region in memory and hands each 32-bit command word to a downstream opcode consumer. Software gives it three byte pointers through a small write port: where the region begins, the first byte past its end, and a put pointer that marks the first byte not yet holding valid commands. The fetcher keeps its own get pointer, which marks the first byte it has not yet finished with, and reports it on a port. Whenever get and put differ it reads the word at get. When they are equal it sits idle.

Two command words are handled inside the block and are not passed on. The restart command sends get back to the region start, because the region does not wrap by itself. The gather command names a second memory area, with a word count and a base address held in the next word. The fetcher streams that many words from the base and then resumes the main region. Gathered words are never decoded as commands. A gather can also mark its words as payload for one incrementing or non-incrementing register write. If get is about to move onto the end address without a restart, the channel halts with an error. The error stays until software writes a new start address or pulses a channel reset.

Top module: `pbuf_fetch`

## Requirements
- R1: After reset, get_ptr is 0, err is 0, and neither mem_req_valid nor out_valid is asserted.
- R2: A write with reg_sel 0 loads the start address, with 1 the end address, and with 2 the put pointer. A start write also reloads get from the new start.
- R3: While get differs from put, the block requests the word at get. When they are equal, and no gather is in progress, it makes no memory request. A pending request keeps its address until it is accepted.
- R4: Words leave in memory order over out_valid/out_ready. A word and out_valid stay stable until the word is accepted. For main-region words, get grows by 4 only when the word is accepted.
- R5: A main-region word with bits [31:28] = 0xE (restart) is not forwarded. It sets get to the start address.
- R6: A main-region word with bits [31:28] = 0xD (gather) carries a word count in bits [CNT_W-1:0] and a mode in bits [27:26]. Its base address is the next word. That many words are read from the base and forwarded. Get then grows by 8, and neither the gather word nor the base word is forwarded.
- R7: Words fetched by a gather are never interpreted. Restart and gather words among them are forwarded unchanged.
- R8: For gather mode 01 the gathered words go out with out_payload 1 and out_kind 1 (incrementing write). For mode 10 they go out with out_payload 1 and out_kind 2 (non-incrementing write). For modes 00 and 11, and for all main-region words, out_payload is 0 and out_kind is 0.
- R9: A gather with a count of 0 reads no gathered words and forwards nothing. Get grows by 8.
- R10: When get would advance onto the end address, or when a gather word sits in the last word of the region, err rises. After that the block makes no memory request and forwards no word.
- R11: A start write or a chan_rst pulse clears err, reloads get from the start address, and drops any word or response still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_rst | input | 1 | One-cycle channel reset pulse |
| reg_we | input | 1 | Pointer register write strobe |
| reg_sel | input | 2 | 0 start, 1 end, 2 put |
| reg_wdata | input | AW | Byte address to write |
| get_ptr | output | AW | Current get pointer |
| err | output | 1 | Ran off the region end |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned word |
| out_valid | output | 1 | Word offered to the consumer |
| out_ready | input | 1 | Consumer accepts the word |
| out_word | output | 32 | Command or data word |
| out_payload | output | 1 | Word is data for an embedded write |
| out_kind | output | 2 | 0 command, 1 incrementing, 2 non-incrementing |

## Verification
The bench builds the block with a 16-bit address width and an 8-bit gather count, so every region, gather base and end boundary fits in a small bench memory. The end pointer can sit only two words past the start, so running off the region end comes up within a few cycles. The memory stub withholds acceptance on one cycle in four, and the consumer is held off for stretches. This exercises request hold and word hold together with plain gathers, embedded-write gathers, empty gathers, a gather in the last word of the region, and the restart-with-put-at-start pattern.

// File: rtl/pbf_pkg.sv
package pbf_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_MREQ,
        ST_MRSP,
        ST_BREQ,
        ST_BRSP,
        ST_GREQ,
        ST_GRSP,
        ST_OUT,
        ST_HALT,
        ST_DROP
    } pbf_state_e;

    typedef enum logic [1:0] {
        KIND_CMD     = 2'd0,
        KIND_INCR    = 2'd1,
        KIND_NONINCR = 2'd2
    } pbf_kind_e;

    localparam logic [3:0] OPC_RESTART = 4'hE;
    localparam logic [3:0] OPC_GATHER  = 4'hD;

    localparam logic [1:0] SEL_START = 2'd0;
    localparam logic [1:0] SEL_END   = 2'd1;
    localparam logic [1:0] SEL_PUT   = 2'd2;

endpackage

// File: rtl/pbf_regs.sv
module pbf_regs
    import pbf_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chan_rst,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] start_addr,
    output logic [AW-1:0] end_addr,
    output logic [AW-1:0] put_addr,
    output logic          kick
);

    typedef struct packed {
        logic [AW-1:0] start;
        logic [AW-1:0] stop;
        logic [AW-1:0] put;
        logic          kick;
    } regs_s;

    regs_s regs_d, regs_q;

    always_comb begin
        regs_d      = regs_q;
        regs_d.kick = chan_rst;
        if (reg_we) begin
            case (reg_sel)
                SEL_START: begin
                    regs_d.start = reg_wdata;
                    regs_d.kick  = 1'b1;
                end
                SEL_END: regs_d.stop = reg_wdata;
                SEL_PUT: regs_d.put  = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign start_addr = regs_q.start;
    assign end_addr   = regs_q.stop;
    assign put_addr   = regs_q.put;
    assign kick       = regs_q.kick;

    // R11
    restart_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_rst || (reg_we && reg_sel == SEL_START)) |=> kick);

    // R2
    put_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_sel == SEL_PUT) |=> $stable(put_addr));

endmodule

// File: rtl/pbf_decode.sv
module pbf_decode
    import pbf_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [31:0]      word,
    output logic             is_restart,
    output logic             is_gather,
    output logic [CNT_W-1:0] count,
    output pbf_kind_e        kind
);

    logic [3:0] opc;
    logic [1:0] mode;

    assign opc        = word[31:28];
    assign mode       = word[27:26];
    assign is_restart = (opc == OPC_RESTART);
    assign is_gather  = (opc == OPC_GATHER);
    assign count      = word[CNT_W-1:0];

    always_comb begin
        case (mode)
            2'b01:   kind = KIND_INCR;
            2'b10:   kind = KIND_NONINCR;
            default: kind = KIND_CMD;
        endcase
    end

endmodule

// File: rtl/pbf_seq.sv
module pbf_seq
    import pbf_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kick,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] end_addr,
    input  logic [AW-1:0] put_addr,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [31:0]   mem_rsp_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [31:0]   out_word,
    output logic          out_payload,
    output logic [1:0]    out_kind,
    output logic [AW-1:0] get_ptr,
    output logic          err
);

    localparam logic [AW-1:0] WORD_STEP = AW'(4);
    localparam logic [AW-1:0] HDR_STEP  = AW'(8);

    typedef struct packed {
        pbf_state_e       state;
        logic [AW-1:0]    get;
        logic [AW-1:0]    gptr;
        logic [CNT_W-1:0] gcnt;
        pbf_kind_e        gkind;
        logic             in_gather;
        logic             err;
        logic [31:0]      word;
        logic             payload;
        pbf_kind_e        kind;
    } seq_s;

    seq_s seq_d, seq_q;

    logic             dec_restart;
    logic             dec_gather;
    logic [CNT_W-1:0] dec_count;
    pbf_kind_e        dec_kind;

    pbf_decode #(.CNT_W(CNT_W)) u_decode (
        .word       (mem_rsp_data),
        .is_restart (dec_restart),
        .is_gather  (dec_gather),
        .count      (dec_count),
        .kind       (dec_kind)
    );

    logic          hs;
    logic          adv;
    logic [AW-1:0] step;
    logic [AW-1:0] nget;
    logic [AW-1:0] get_next_word;
    logic          wait_rsp;
    logic          in_req;

    assign get_next_word = seq_q.get + WORD_STEP;

    always_comb begin
        seq_d = seq_q;
        adv   = 1'b0;
        step  = '0;

        in_req   = (seq_q.state == ST_MREQ) || (seq_q.state == ST_BREQ) ||
                   (seq_q.state == ST_GREQ);
        wait_rsp = (seq_q.state == ST_MRSP) || (seq_q.state == ST_BRSP) ||
                   (seq_q.state == ST_GRSP) || (seq_q.state == ST_DROP);

        mem_req_valid = in_req;
        case (seq_q.state)
            ST_BREQ: mem_req_addr = get_next_word;
            ST_GREQ: mem_req_addr = seq_q.gptr;
            default: mem_req_addr = seq_q.get;
        endcase
        hs = in_req && mem_req_ready;

        case (seq_q.state)
            ST_IDLE: begin
                if (seq_q.get != put_addr) seq_d.state = ST_MREQ;
            end
            ST_MREQ: if (hs) seq_d.state = ST_MRSP;
            ST_MRSP: begin
                if (mem_rsp_valid) begin
                    if (dec_restart) begin
                        seq_d.get   = start_addr;
                        seq_d.state = ST_IDLE;
                    end else if (dec_gather) begin
                        seq_d.gcnt  = dec_count;
                        seq_d.gkind = dec_kind;
                        if (get_next_word == end_addr) begin
                            seq_d.err   = 1'b1;
                            seq_d.state = ST_HALT;
                        end else begin
                            seq_d.state = ST_BREQ;
                        end
                    end else begin
                        seq_d.word      = mem_rsp_data;
                        seq_d.payload   = 1'b0;
                        seq_d.kind      = KIND_CMD;
                        seq_d.in_gather = 1'b0;
                        seq_d.state     = ST_OUT;
                    end
                end
            end
            ST_BREQ: if (hs) seq_d.state = ST_BRSP;
            ST_BRSP: begin
                if (mem_rsp_valid) begin
                    seq_d.gptr = mem_rsp_data[AW-1:0];
                    if (seq_q.gcnt == '0) begin
                        adv  = 1'b1;
                        step = HDR_STEP;
                    end else begin
                        seq_d.state = ST_GREQ;
                    end
                end
            end
            ST_GREQ: if (hs) seq_d.state = ST_GRSP;
            ST_GRSP: begin
                if (mem_rsp_valid) begin
                    seq_d.word      = mem_rsp_data;
                    seq_d.payload   = (seq_q.gkind != KIND_CMD);
                    seq_d.kind      = seq_q.gkind;
                    seq_d.in_gather = 1'b1;
                    seq_d.state     = ST_OUT;
                end
            end
            ST_OUT: begin
                if (out_ready) begin
                    if (seq_q.in_gather) begin
                        seq_d.gptr = seq_q.gptr + WORD_STEP;
                        seq_d.gcnt = seq_q.gcnt - 1'b1;
                        if (seq_q.gcnt == CNT_W'(1)) begin
                            seq_d.in_gather = 1'b0;
                            adv  = 1'b1;
                            step = HDR_STEP;
                        end else begin
                            seq_d.state = ST_GREQ;
                        end
                    end else begin
                        adv  = 1'b1;
                        step = WORD_STEP;
                    end
                end
            end
            ST_HALT: ;
            ST_DROP: if (mem_rsp_valid) seq_d.state = ST_IDLE;
            default: seq_d.state = ST_IDLE;
        endcase

        nget = seq_q.get + step;
        if (adv) begin
            seq_d.get = nget;
            if (nget == end_addr) begin
                seq_d.err   = 1'b1;
                seq_d.state = ST_HALT;
            end else begin
                seq_d.state = ST_IDLE;
            end
        end

        if (kick) begin
            seq_d.get       = start_addr;
            seq_d.err       = 1'b0;
            seq_d.in_gather = 1'b0;
            if ((wait_rsp && !mem_rsp_valid) || hs) seq_d.state = ST_DROP;
            else                                     seq_d.state = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= ST_IDLE;
            seq_q.gkind <= KIND_CMD;
            seq_q.kind  <= KIND_CMD;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign out_valid   = (seq_q.state == ST_OUT);
    assign out_word    = seq_q.word;
    assign out_payload = seq_q.payload;
    assign out_kind    = seq_q.kind;
    assign get_ptr     = seq_q.get;
    assign err         = seq_q.err;

    // R4
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !kick) |=> (out_valid && $stable(out_word)));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready && !kick) |=>
            (mem_req_valid && $stable(mem_req_addr)));

    // R6
    get_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !kick |=> (get_ptr == $past(get_ptr) ||
                   get_ptr == $past(get_ptr) + WORD_STEP ||
                   get_ptr == $past(get_ptr) + HDR_STEP ||
                   get_ptr == start_addr));

    // R10
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!mem_req_valid && !out_valid));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !kick) |=> err);

    // R8
    payload_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_payload == (out_kind != 2'd0)));

endmodule

// File: rtl/pbuf_fetch.sv
module pbuf_fetch
    import pbf_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chan_rst,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] get_ptr,
    output logic          err,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [31:0]   mem_rsp_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [31:0]   out_word,
    output logic          out_payload,
    output logic [1:0]    out_kind
);

    logic [AW-1:0] start_addr;
    logic [AW-1:0] end_addr;
    logic [AW-1:0] put_addr;
    logic          kick;

    pbf_regs #(.AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_rst   (chan_rst),
        .reg_we     (reg_we),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .start_addr (start_addr),
        .end_addr   (end_addr),
        .put_addr   (put_addr),
        .kick       (kick)
    );

    pbf_seq #(.AW(AW), .CNT_W(CNT_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .kick          (kick),
        .start_addr    (start_addr),
        .end_addr      (end_addr),
        .put_addr      (put_addr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .out_word      (out_word),
        .out_payload   (out_payload),
        .out_kind      (out_kind),
        .get_ptr       (get_ptr),
        .err           (err)
    );

endmodule

// File: tb/pbuf_fetch_bench.sv
module pbuf_fetch_bench;

    localparam int AW    = 16;
    localparam int CNT_W = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          chan_rst;
    logic          reg_we;
    logic [1:0]    reg_sel;
    logic [AW-1:0] reg_wdata;
    logic [AW-1:0] get_ptr;
    logic          err;
    logic          mem_req_valid;
    logic          mem_req_ready;
    logic [AW-1:0] mem_req_addr;
    logic          mem_rsp_valid;
    logic [31:0]   mem_rsp_data;
    logic          out_valid;
    logic          out_ready;
    logic [31:0]   out_word;
    logic          out_payload;
    logic [1:0]    out_kind;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] mem [0:1023];
    logic [1:0]  cyc;

    logic [31:0] cap_word [0:63];
    logic        cap_pay  [0:63];
    logic [1:0]  cap_kind [0:63];
    int          cap_n;

    always #5 clk = ~clk;

    pbuf_fetch #(.AW(AW), .CNT_W(CNT_W)) u_pbuf_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .chan_rst      (chan_rst),
        .reg_we        (reg_we),
        .reg_sel       (reg_sel),
        .reg_wdata     (reg_wdata),
        .get_ptr       (get_ptr),
        .err           (err),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .out_word      (out_word),
        .out_payload   (out_payload),
        .out_kind      (out_kind)
    );

    assign mem_req_ready = (cyc != 2'd3);

    always @(posedge clk) begin
        if (!rst_n) begin
            cyc           <= '0;
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
            cap_n         <= 0;
        end else begin
            cyc           <= cyc + 2'd1;
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem[mem_req_addr[11:2]];
            end
            if (out_valid && out_ready && cap_n < 64) begin
                cap_word[cap_n] <= out_word;
                cap_pay[cap_n]  <= out_payload;
                cap_kind[cap_n] <= out_kind;
                cap_n           <= cap_n + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [AW-1:0] val);
        reg_we    = 1'b1;
        reg_sel   = sel;
        reg_wdata = val;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input logic [AW-1:0] s, input logic [AW-1:0] e);
        wr(2'd1, e);
        wr(2'd0, s);
        wr(2'd2, s);
        run(3);
    endtask

    task automatic poke(input int addr, input logic [31:0] val);
        mem[addr >> 2] = val;
    endtask

    task automatic t_reset;
        chk("R1 get", 32'(get_ptr), 32'h0);
        chk("R1 err", 32'(err), 32'h0);
        chk("R1 req", 32'(mem_req_valid), 32'h0);
        chk("R1 out", 32'(out_valid), 32'h0);
    endtask

    task automatic t_linear;
        int base;
        poke(32'h100, 32'h11111111);
        poke(32'h104, 32'h22222222);
        poke(32'h108, 32'h33333333);
        setup(16'h0100, 16'h0200);
        chk("R2 get reload", 32'(get_ptr), 32'h100);
        chk("R3 idle when equal", 32'(mem_req_valid), 32'h0);
        base = cap_n;
        out_ready = 1'b1;
        wr(2'd2, 16'h010C);
        run(40);
        chk("R4 count", 32'(cap_n - base), 32'd3);
        chk("R4 word0", cap_word[base], 32'h11111111);
        chk("R4 word1", cap_word[base+1], 32'h22222222);
        chk("R4 word2", cap_word[base+2], 32'h33333333);
        chk("R8 main kind", 32'({cap_pay[base], cap_kind[base]}), 32'h0);
        chk("R4 get", 32'(get_ptr), 32'h10C);
        chk("R3 idle after", 32'(mem_req_valid), 32'h0);
    endtask

    task automatic t_backpressure;
        int base;
        poke(32'h140, 32'hAAAA0001);
        poke(32'h144, 32'hBBBB0002);
        setup(16'h0140, 16'h0200);
        out_ready = 1'b0;
        base = cap_n;
        wr(2'd2, 16'h0148);
        run(20);
        chk("R4 held valid", 32'(out_valid), 32'h1);
        chk("R4 held word", out_word, 32'hAAAA0001);
        chk("R4 get waits", 32'(get_ptr), 32'h140);
        run(5);
        chk("R4 still held", out_word, 32'hAAAA0001);
        out_ready = 1'b1;
        run(20);
        chk("R4 bp count", 32'(cap_n - base), 32'd2);
        chk("R4 bp order", cap_word[base+1], 32'hBBBB0002);
        chk("R4 bp get", 32'(get_ptr), 32'h148);
    endtask

    task automatic t_restart;
        int base;
        poke(32'h180, 32'hC0C0C0C0);
        poke(32'h184, 32'hE0000000);
        setup(16'h0180, 16'h0200);
        out_ready = 1'b1;
        base = cap_n;
        wr(2'd2, 16'h0184);
        run(20);
        chk("R5 pre get", 32'(get_ptr), 32'h184);
        wr(2'd2, 16'h0180);
        run(20);
        chk("R5 not forwarded", 32'(cap_n - base), 32'd1);
        chk("R5 get rewound", 32'(get_ptr), 32'h180);
        chk("R5 idle", 32'(mem_req_valid), 32'h0);
    endtask

    task automatic t_gather_plain;
        int base;
        poke(32'h200, 32'hD0000003);
        poke(32'h204, 32'h00000800);
        poke(32'h208, 32'h55555555);
        poke(32'h800, 32'h00000011);
        poke(32'h804, 32'hD0000005);
        poke(32'h808, 32'hE0000000);
        setup(16'h0200, 16'h0300);
        out_ready = 1'b1;
        base = cap_n;
        wr(2'd2, 16'h020C);
        run(60);
        chk("R6 count", 32'(cap_n - base), 32'd4);
        chk("R6 first", cap_word[base], 32'h00000011);
        chk("R7 nested gather", cap_word[base+1], 32'hD0000005);
        chk("R7 inner restart", cap_word[base+2], 32'hE0000000);
        chk("R8 plain flags", 32'({cap_pay[base+1], cap_kind[base+1]}), 32'h0);
        chk("R6 resume", cap_word[base+3], 32'h55555555);
        chk("R6 get", 32'(get_ptr), 32'h20C);
    endtask

    task automatic t_gather_embed;
        int base;
        poke(32'h400, 32'hD4000002);
        poke(32'h404, 32'h00000900);
        poke(32'h408, 32'hD8000001);
        poke(32'h40C, 32'h00000910);
        poke(32'h900, 32'h000000A0);
        poke(32'h904, 32'h000000A1);
        poke(32'h910, 32'h000000B0);
        setup(16'h0400, 16'h0500);
        out_ready = 1'b1;
        base = cap_n;
        wr(2'd2, 16'h0410);
        run(60);
        chk("R8 count", 32'(cap_n - base), 32'd3);
        chk("R8 incr word", cap_word[base+1], 32'h000000A1);
        chk("R8 incr flags", 32'({cap_pay[base+1], cap_kind[base+1]}), 32'h5);
        chk("R8 nonincr word", cap_word[base+2], 32'h000000B0);
        chk("R8 nonincr flags", 32'({cap_pay[base+2], cap_kind[base+2]}), 32'h6);
        chk("R6 embed get", 32'(get_ptr), 32'h410);
    endtask

    task automatic t_gather_zero;
        int base;
        poke(32'h500, 32'hD0000000);
        poke(32'h504, 32'h00000980);
        poke(32'h508, 32'h00000077);
        setup(16'h0500, 16'h0600);
        out_ready = 1'b1;
        base = cap_n;
        wr(2'd2, 16'h050C);
        run(40);
        chk("R9 count", 32'(cap_n - base), 32'd1);
        chk("R9 word", cap_word[base], 32'h00000077);
        chk("R9 get", 32'(get_ptr), 32'h50C);
    endtask

    task automatic t_end_error;
        int base;
        poke(32'h600, 32'h00000061);
        poke(32'h604, 32'h00000062);
        setup(16'h0600, 16'h0608);
        out_ready = 1'b1;
        base = cap_n;
        wr(2'd2, 16'h0610);
        run(40);
        chk("R10 words before end", 32'(cap_n - base), 32'd2);
        chk("R10 err", 32'(err), 32'h1);
        chk("R10 get at end", 32'(get_ptr), 32'h608);
        chk("R10 no request", 32'(mem_req_valid), 32'h0);
        run(10);
        chk("R10 err sticky", 32'(err), 32'h1);
    endtask

    task automatic t_clear_start;
        setup(16'h0700, 16'h0800);
        chk("R11 start clears err", 32'(err), 32'h0);
        chk("R11 start reloads get", 32'(get_ptr), 32'h700);
    endtask

    task automatic t_gather_last;
        int base;
        poke(32'hA00, 32'h0000005A);
        poke(32'hA04, 32'hD0000001);
        setup(16'h0A00, 16'h0A08);
        out_ready = 1'b1;
        base = cap_n;
        wr(2'd2, 16'h0A08);
        run(40);
        chk("R10 last word count", 32'(cap_n - base), 32'd1);
        chk("R10 last word err", 32'(err), 32'h1);
        chk("R10 last word get", 32'(get_ptr), 32'hA04);
    endtask

    task automatic t_chan_rst;
        chan_rst = 1'b1;
        @(negedge clk);
        chan_rst = 1'b0;
        @(negedge clk);
        chk("R11 chan_rst clears err", 32'(err), 32'h0);
        chk("R11 chan_rst reloads get", 32'(get_ptr), 32'hA00);
        setup(16'h0700, 16'h0800);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        rst_n     = 1'b0;
        chan_rst  = 1'b0;
        reg_we    = 1'b0;
        reg_sel   = '0;
        reg_wdata = '0;
        out_ready = 1'b0;
        run(4);
        rst_n = 1'b1;
        run(2);
        t_reset();
        t_linear();
        t_backpressure();
        t_restart();
        t_gather_plain();
        t_gather_embed();
        t_gather_zero();
        t_end_error();
        t_clear_start();
        t_gather_last();
        t_chan_rst();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule